// File: doc/BRIEF.md
# Reed-Solomon (63,51) Encoder with Wide-Symbol Repacking

This block sits after an outer encoder whose symbols are 102 bits wide. Three such wide symbols are taken one after another and together form one message. Each wide symbol is cut into seventeen 6-bit field symbols, which gives 51 message symbols over GF(64). The block then encodes them systematically with a (63,51) Reed-Solomon code: it streams the 51 message symbols out unchanged and follows them with 12 parity symbols. Each codeword is 63 symbols (378 bits), so the code rate is 51/63.

Parity comes from a 12-stage division register with a constant GF(64) multiplier on each stage. The field uses the primitive polynomial x^6+x+1. The generator polynomial has the roots alpha^1 to alpha^12, so the code corrects up to six symbol errors.

Both edges of the block use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. The output holds its symbol and its last flag for as long as it waits for ready. The input stops taking words during the parity phase, and the next message starts only after all 63 symbols of the current codeword have left. Ready at the input never depends on valid in the same cycle.

Top module: `rsenc63`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, out_valid is 0 and in_ready is 1.
- R2: The first 51 output symbols of a codeword are the message. Each 102-bit input word is split most-significant bits first: the first symbol is in_data[101:96] and the last is in_data[5:0]. All 17 symbols of the first accepted word come before those of the second, and the second before the third.
- R3: Take the 63 output symbols as the coefficients of a polynomial, with the first symbol as the x^62 term. Field arithmetic uses x^6+x+1, with bit i of a symbol as the coefficient of alpha^i. This polynomial evaluates to zero at each of alpha^1 to alpha^12.
- R4: out_last is 1 on the 63rd symbol of each codeword and 0 on every other output symbol.
- R5: While out_valid is 1 and out_ready is 0, the next cycle keeps out_valid at 1 and keeps out_data and out_last unchanged.
- R6: Exactly three input words are accepted per codeword. in_ready stays 0 from the start of the parity phase until the last symbol has been taken. A word offered with in_valid during that time is not consumed; it becomes the first word of the next codeword.
- R7: The parity register starts each codeword cleared. Codewords sent back to back each meet R3 on their own, and an all-zero message gives 12 zero parity symbols.
- R8: Once the 51st message symbol has been taken, out_valid stays 1 for all 12 parity symbols. Parity output waits only on out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block can take an input word |
| in_data | input | 102 | Wide outer-code symbol |
| out_valid | output | 1 | out_data holds a codeword symbol |
| out_ready | input | 1 | The downstream side takes the symbol |
| out_data | output | 6 | Codeword symbol over GF(64) |
| out_last | output | 1 | Marks the final symbol of a codeword |

## Verification
Two events can fall in the same cycle: the last parity symbol of one codeword leaving while the first word of the next codeword is already being offered. Likewise, a message symbol can be taken in the same cycle that the division register updates and the input gate re-opens. The bench holds in_valid high for the whole run, so the next word is always waiting at the boundary. On odd codewords it also throttles out_ready with a pseudo-random pattern. Each codeword is judged by three things: a message comparison, the twelve syndromes computed in the bench, and the count of words consumed. A word taken too early, or parity left over from the previous codeword, would fail these checks.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;
  localparam int SYM_W = 6;
  localparam int MAX_PAR = 32;
  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [MAX_PAR:0] gvec_t;

  // multiply by alpha modulo x^6+x+1
  function automatic sym_t gf_xtime(sym_t a);
    return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? sym_t'(6'b000011) : sym_t'(0));
  endfunction

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc = '0;
    sym_t sh = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // product of (x + alpha^i) for i = 1..npar, coefficient j at index j
  function automatic gvec_t gen_poly(int npar);
    gvec_t g = '0;
    sym_t root = sym_t'(1);
    g[0] = sym_t'(1);
    for (int i = 1; i <= npar; i++) begin
      root = gf_xtime(root);
      for (int j = MAX_PAR; j >= 0; j--) begin
        g[j] = ((j > 0) ? g[j-1] : sym_t'(0)) ^ gf_mul(root, g[j]);
      end
    end
    return g;
  endfunction
endpackage

// File: rtl/rsenc_unpack.sv
module rsenc_unpack
  import rsenc_pkg::*;
#(
  parameter int WORD_W = 102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              take,
  output sym_t              head,
  output logic              full
);
  localparam int SPW   = WORD_W / SYM_W;
  localparam int CNT_W = $clog2(SPW);

  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;

  assign head = hold_q[WORD_W-1 -: SYM_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
      full   <= 1'b0;
    end else if (load) begin
      hold_q <= din;
      cnt_q  <= '0;
      full   <= 1'b1;
    end else if (take) begin
      hold_q <= hold_q << SYM_W;
      if (cnt_q == CNT_W'(SPW - 1)) full <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsenc_parity.sv
module rsenc_parity
  import rsenc_pkg::*;
#(
  parameter int NPAR = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic msg_step,
  input  logic out_step,
  input  sym_t din,
  output sym_t par_out
);
  localparam gvec_t GEN = gen_poly(NPAR);

  sym_t stage_q [NPAR];
  sym_t fb;

  assign fb      = msg_step ? (din ^ stage_q[NPAR-1]) : sym_t'(0);
  assign par_out = stage_q[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    sym_t prev;
    if (i == 0) begin : g_head
      assign prev = '0;
    end else begin : g_tail
      assign prev = stage_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear)  stage_q[i] <= '0;
      else if (msg_step)    stage_q[i] <= prev ^ gf_mul(GEN[i], fb);
      else if (out_step)    stage_q[i] <= prev;
    end
  end
endmodule

// File: rtl/rsenc_seq.sv
module rsenc_seq #(
  parameter int N     = 63,
  parameter int K     = 51,
  parameter int WORDS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_fire,
  input  logic out_fire,
  output logic par_phase,
  output logic word_room,
  output logic last
);
  localparam int POS_W = $clog2(N);
  localparam int WC_W  = $clog2(WORDS + 1);

  logic [POS_W-1:0] pos_q;
  logic [WC_W-1:0]  words_q;

  assign par_phase = pos_q >= POS_W'(K);
  assign last      = pos_q == POS_W'(N - 1);
  assign word_room = words_q < WC_W'(WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      words_q <= '0;
    end else begin
      if (out_fire) pos_q <= last ? '0 : pos_q + 1'b1;
      if (out_fire && last) words_q <= '0;
      else if (in_fire)     words_q <= words_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsenc63.sv
module rsenc63
  import rsenc_pkg::*;
#(
  parameter int WORD_W = 102,
  parameter int WORDS  = 3,
  parameter int N      = 63,
  parameter int K      = 51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [5:0]        out_data,
  output logic              out_last
);
  localparam int NPAR = N - K;

  logic in_fire, out_fire, par_phase, word_room, full;
  sym_t head, par_out;

  assign in_ready  = !full && word_room;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = par_phase || full;
  assign out_fire  = out_valid && out_ready;
  assign out_data  = par_phase ? par_out : head;

  rsenc_seq #(.N(N), .K(K), .WORDS(WORDS)) u_seq (
    .clk, .rst_n, .in_fire, .out_fire,
    .par_phase, .word_room, .last(out_last)
  );

  rsenc_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk, .rst_n, .load(in_fire), .din(in_data),
    .take(out_fire && !par_phase), .head, .full
  );

  rsenc_parity #(.NPAR(NPAR)) u_par (
    .clk, .rst_n,
    .clear(out_fire && out_last),
    .msg_step(out_fire && !par_phase),
    .out_step(out_fire && par_phase),
    .din(head), .par_out
  );
endmodule

// File: rtl/rsenc63_chk.sv
module rsenc63_chk #(
  parameter int N     = 63,
  parameter int K     = 51,
  parameter int WORDS = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [5:0] out_data,
  input logic       out_last
);
  int ocnt, icnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocnt <= 0;
      icnt <= 0;
    end else begin
      if (out_valid && out_ready) ocnt <= (ocnt == N - 1) ? 0 : ocnt + 1;
      if (out_valid && out_ready && ocnt == N - 1) icnt <= 0;
      else if (in_valid && in_ready) icnt <= icnt + 1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R5
  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> ocnt == N - 1); // R4
  AST_GATE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt >= K |-> !in_ready); // R6
  AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> icnt < WORDS); // R6
  AST_PARITY_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt >= K |-> out_valid); // R8
endmodule

bind rsenc63 rsenc63_chk #(.N(N), .K(K), .WORDS(WORDS)) u_chk (.*);

// File: tb/rsenc63_tb.sv
module rsenc63_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCW = 55;
  localparam int NWORD = NCW * 3;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [101:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [5:0] out_data;
  logic out_last;

  int checks = 0;
  int errors = 0;

  logic [5:0]   msg   [NCW][51];
  logic [101:0] words [NWORD];
  logic [5:0]   got   [63];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsenc63 u_dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] tb_mul(logic [5:0] a, logic [5:0] b);
    logic [11:0] r = '0;
    for (int i = 0; i < 6; i++) if (b[i]) r = r ^ (12'(a) << i);
    for (int k = 11; k >= 6; k--) if (r[k]) r = r ^ (12'h043 << (k - 6));
    return r[5:0];
  endfunction

  task automatic judge(input int cw);
    int bad = 0;
    int nz = 0;
    logic [5:0] a = 6'd1;
    for (int s = 0; s < 51; s++) if (got[s] !== msg[cw][s]) bad++;
    check(bad == 0, "R2 message order", bad, 0);
    bad = 0;
    for (int j = 1; j <= 12; j++) begin
      logic [5:0] syn = '0;
      a = tb_mul(a, 6'd2);
      for (int p = 0; p < 63; p++) syn = tb_mul(syn, a) ^ got[p];
      if (syn != 0) bad++;
    end
    check(bad == 0, "R3 R7 syndromes", bad, 0);
    if (cw == 51) begin
      for (int p = 51; p < 63; p++) if (got[p] != 0) nz++;
      check(nz == 0, "R7 zero message parity", nz, 0);
    end
  endtask

  initial begin
    int widx = 0;
    int cw = 0;
    int pos = 0;
    int cyc = 0;
    int stall_bad = 0;
    int last_bad = 0;
    int gate_bad = 0;
    int flow_bad = 0;
    bit prev_stall = 0;
    logic [5:0] prev_data = '0;
    logic prev_last = 0;
    logic [15:0] lf = 16'hACE1;
    logic [7:0] pr = 8'h5B;

    for (int c = 0; c < NCW; c++)
      for (int s = 0; s < 51; s++) begin
        if (c < 51)       msg[c][s] = (s == c) ? 6'((c % 63) + 1) : 6'd0;
        else if (c == 51) msg[c][s] = 6'd0;
        else if (c == 52) msg[c][s] = 6'h3F;
        else if (c == 53) msg[c][s] = 6'(s);
        else begin
          pr = {pr[6:0], pr[7] ^ pr[5] ^ pr[4] ^ pr[3]};
          msg[c][s] = pr[5:0];
        end
      end
    for (int c = 0; c < NCW; c++)
      for (int w = 0; w < 3; w++) begin
        words[c*3+w] = '0;
        for (int s = 0; s < 17; s++) words[c*3+w][101-6*s -: 6] = msg[c][w*17+s];
      end

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    while (cw < NCW && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      in_valid = (widx < NWORD);
      in_data  = (widx < NWORD) ? words[widx] : '0;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = (cw % 2 == 0) ? 1'b1 : lf[0];
      #1;
      if (prev_stall && !(out_valid && out_data == prev_data && out_last == prev_last)) stall_bad++;
      if (pos >= 51) begin
        if (in_ready) gate_bad++;
        if (!out_valid) flow_bad++;
      end
      if (in_valid && in_ready) widx++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        got[pos] = out_data;
        if (out_last != (pos == 62)) last_bad++;
        if (pos == 62) begin
          judge(cw);
          cw++;
          pos = 0;
        end else pos++;
      end
    end

    if (cyc >= LIMIT) check(1'b0, "watchdog", cyc, LIMIT);
    check(stall_bad == 0, "R5 hold under stall", stall_bad, 0);
    check(last_bad == 0, "R4 last flag", last_bad, 0);
    check(gate_bad == 0, "R6 input gated in parity", gate_bad, 0);
    check(flow_bad == 0, "R8 parity continuous", flow_bad, 0);
    check(widx == NWORD, "R6 words consumed", widx, NWORD);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule